// File: doc/BRIEF.md
# Zero-Terminated One-Shot Pulse Timer

This block produces one timed pulse per cycle of a digitally programmed oscillator. The oscillator period is set between two limits. One register holds the period at the slowest rate and one holds the period at the fastest rate. A control word picks a point between them on a straight line. Each new oscillator cycle raises a one-cycle strobe and starts a pulse.

The pulse normally ends when an external zero-crossing indication arrives. That input passes through a two-stage synchronizer, and it is ignored until the pulse has run for a programmable blanking count. If no zero indication comes in time, the pulse ends when it reaches a programmable maximum width. A flag then shows that the pulse was cut by the width limit. If the next oscillator cycle begins while a pulse is still running, the running pulse is cut off and a fresh one starts.

The block serves as the timing core of a resonant converter controller. The enable input holds the whole timer idle with its outputs low.

Top module: `zero_term_oneshot`

## Requirements
- R1: While enable is high, cycleStart is a single-cycle strobe that repeats every P clock cycles, where P is the effective period. The first strobe is high in the cycle right after the first clock edge that samples enable high.
- R2: The raw period is slowPeriod − floor((slowPeriod − fastPeriod) × rateCtrl / 255), for an 8-bit rateCtrl. This gives slowPeriod at rateCtrl 0 and fastPeriod at rateCtrl 255. If fastPeriod exceeds slowPeriod, the span is taken as zero. A raw period below 2 is raised to 2.
- R3: pulseOut is high in every cycle where cycleStart is high.
- R4: A zero indication that has fully passed through the synchronizer before the pulse has lasted blankCycles cycles has no effect on the pulse.
- R5: zeroDetect is first driven high in the cycle at offset d from the strobe cycle (offset 0), and stays high. The pulse then lasts max(d+3, max(blankCycles,1)) cycles, provided this is below the width limit. The extra 3 cycles come from the two synchronizer stages and the end decision register. A zero held high from before the strobe gives a width of max(blankCycles,1).
- R6: If the pulse is not ended by zero, it lasts max(maxWidthCycles,1) cycles. maxWidthHit goes high in the cycle where pulseOut falls, and stays high until the next cycleStart.
- R7: When the zero end and the width limit fall on the same cycle, the zero end wins and maxWidthHit stays low.
- R8: When a cycle start arrives during a running pulse, pulseOut stays high and its width count restarts from the strobe. maxWidthHit is not set by the earlier pulse.
- R9: One cycle after a clock edge that samples enable low, pulseOut, cycleStart and maxWidthHit are all low. The phase and width counters are cleared, so re-enabling starts a fresh cycle as in R1.
- R10: After reset, with enable low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the oscillator and pulse timer when high |
| rateCtrl | input | 8 | Rate control word, 0 = slowest, 255 = fastest |
| slowPeriod | input | 16 | Oscillator period in cycles at the slowest rate |
| fastPeriod | input | 16 | Oscillator period in cycles at the fastest rate |
| blankCycles | input | 16 | Pulse length before zero indications are accepted |
| maxWidthCycles | input | 16 | Longest pulse length in cycles |
| zeroDetect | input | 1 | Asynchronous zero-crossing indication, active high |
| pulseOut | output | 1 | One-shot pulse |
| cycleStart | output | 1 | Single-cycle strobe at each oscillator cycle start |
| maxWidthHit | output | 1 | Last pulse ended on the width limit |

## Verification
Some properties are checked on every cycle. A strobe is always joined by a high pulse and never lasts two cycles. Dropping enable forces the outputs low and clears the counters. A pulse never ends while it is inside both its blanking window and its width limit. The flag rises only as the pulse falls. The exact oscillator period for each control word, and the pulse widths set by the synchronizer delay, blanking, the width limit and their tie, can only be shown by the bench. It measures these over random and directed scenarios against widths it computes itself. Truncation by a short period and the rejection of a brief early zero also come from directed scenarios.

// File: rtl/zto_pkg.sv
package zto_pkg;

  // Strobes from the control to the datapath, decided once per cycle
  typedef struct packed {
    logic clearAll;
    logic startCycle;
    logic endZero;
    logic endMax;
  } zto_strobe_t;

  // Status fed back from the datapath to the control
  typedef struct packed {
    logic running;
    logic phaseWrap;
    logic pulseActive;
    logic blankPassed;
    logic widthReached;
    logic zeroSeen;
  } zto_status_t;

endpackage

// File: rtl/zto_period_calc.sv
module zto_period_calc #(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] rateCtrl,
  input  logic [CNT_W-1:0]  slowPeriod,
  input  logic [CNT_W-1:0]  fastPeriod,
  output logic [CNT_W-1:0]  period
);
  localparam int CTRL_MAX = (1 << CTRL_W) - 1;
  localparam int PROD_W   = CNT_W + CTRL_W;
  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);

  logic [CNT_W-1:0]  span;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] scaled;
  logic [CNT_W-1:0]  rawPeriod;

  always_comb begin
    span      = (slowPeriod > fastPeriod) ? (slowPeriod - fastPeriod) : '0;
    product   = PROD_W'(span) * PROD_W'(rateCtrl);
    scaled    = product / PROD_W'(CTRL_MAX);
    // scaled never exceeds span, so the subtraction cannot wrap
    rawPeriod = slowPeriod - scaled[CNT_W-1:0];
    period    = (rawPeriod < MIN_PERIOD) ? MIN_PERIOD : rawPeriod;
  end
endmodule

// File: rtl/zto_sync.sv
module zto_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/zto_ctrl.sv
module zto_ctrl
  import zto_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  zto_status_t status,
  output zto_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (!enable) begin
      strobe.clearAll = 1'b1;
    end else begin
      // a new cycle has priority over any pulse ending (truncation)
      strobe.startCycle = !status.running || status.phaseWrap;
      if (!strobe.startCycle && status.pulseActive) begin
        if (status.blankPassed && status.zeroSeen) strobe.endZero = 1'b1;
        else if (status.widthReached)              strobe.endMax  = 1'b1;
      end
    end
  end

  // R7: zero end and width end are never issued together
  p_single_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.startCycle, strobe.endZero, strobe.endMax}) <= 1);
endmodule

// File: rtl/zto_datapath.sv
module zto_datapath
  import zto_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zto_strobe_t       strobe,
  input  logic [CTRL_W-1:0] rateCtrl,
  input  logic [CNT_W-1:0]  slowPeriod,
  input  logic [CNT_W-1:0]  fastPeriod,
  input  logic [CNT_W-1:0]  blankCycles,
  input  logic [CNT_W-1:0]  maxWidthCycles,
  input  logic              zeroDetect,
  output zto_status_t       status,
  output logic              pulseOut,
  output logic              cycleStart,
  output logic              maxWidthHit
);
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] widthCnt;
  logic             running;
  logic             pulseQ;
  logic             cycleStartQ;
  logic             maxHitQ;
  logic             zeroSync;

  zto_period_calc #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) i_period (
    .rateCtrl   (rateCtrl),
    .slowPeriod (slowPeriod),
    .fastPeriod (fastPeriod),
    .period     (period)
  );

  zto_sync #(.STAGES(SYNC_STAGES)) i_zsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (zeroDetect),
    .syncOut (zeroSync)
  );

  // Oscillator phase counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt    <= '0;
      running     <= 1'b0;
      cycleStartQ <= 1'b0;
    end else if (strobe.clearAll) begin
      phaseCnt    <= '0;
      running     <= 1'b0;
      cycleStartQ <= 1'b0;
    end else begin
      running     <= 1'b1;
      cycleStartQ <= strobe.startCycle;
      phaseCnt    <= strobe.startCycle ? '0 : phaseCnt + 1'b1;
    end
  end

  // Pulse width counter and pulse state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widthCnt <= '0;
      pulseQ   <= 1'b0;
      maxHitQ  <= 1'b0;
    end else if (strobe.clearAll) begin
      widthCnt <= '0;
      pulseQ   <= 1'b0;
      maxHitQ  <= 1'b0;
    end else if (strobe.startCycle) begin
      widthCnt <= CNT_W'(1);
      pulseQ   <= 1'b1;
      maxHitQ  <= 1'b0;
    end else if (strobe.endZero) begin
      pulseQ   <= 1'b0;
      maxHitQ  <= 1'b0;
    end else if (strobe.endMax) begin
      pulseQ   <= 1'b0;
      maxHitQ  <= 1'b1;
    end else if (pulseQ) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  always_comb begin
    status.running      = running;
    status.phaseWrap    = (phaseCnt >= period - 1'b1);
    status.pulseActive  = pulseQ;
    status.blankPassed  = (widthCnt >= blankCycles);
    status.widthReached = (widthCnt >= maxWidthCycles);
    status.zeroSeen     = zeroSync;
  end

  assign pulseOut    = pulseQ;
  assign cycleStart  = cycleStartQ;
  assign maxWidthHit = maxHitQ;

  // R4: inside blanking and below the limit, the pulse cannot end
  p_no_early_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseQ && !strobe.clearAll && widthCnt < blankCycles && widthCnt < maxWidthCycles)
      |=> pulseQ);

  // R6: the width flag only rises as the pulse falls
  p_flag_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(maxHitQ) |-> $fell(pulseQ));

  // R9: counters are cleared after a disabled edge
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (phaseCnt == '0 && widthCnt == '0 && !running));
endmodule

// File: rtl/zero_term_oneshot.sv
module zero_term_oneshot
  import zto_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CTRL_W-1:0] rateCtrl,
  input  logic [CNT_W-1:0]  slowPeriod,
  input  logic [CNT_W-1:0]  fastPeriod,
  input  logic [CNT_W-1:0]  blankCycles,
  input  logic [CNT_W-1:0]  maxWidthCycles,
  input  logic              zeroDetect,
  output logic              pulseOut,
  output logic              cycleStart,
  output logic              maxWidthHit
);
  zto_strobe_t strobe;
  zto_status_t status;

  zto_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .status (status),
    .strobe (strobe)
  );

  zto_datapath #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .rateCtrl       (rateCtrl),
    .slowPeriod     (slowPeriod),
    .fastPeriod     (fastPeriod),
    .blankCycles    (blankCycles),
    .maxWidthCycles (maxWidthCycles),
    .zeroDetect     (zeroDetect),
    .status         (status),
    .pulseOut       (pulseOut),
    .cycleStart     (cycleStart),
    .maxWidthHit    (maxWidthHit)
  );

  // R3: every strobe cycle carries a high pulse
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |-> pulseOut);

  // R1: the strobe lasts one cycle (period is at least 2)
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |=> !cycleStart);

  // R9: a disabled edge forces all outputs low
  p_disable_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pulseOut && !cycleStart && !maxWidthHit));
endmodule

// File: tb/test_zero_term_oneshot.sv
module test_zero_term_oneshot;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  rateCtrl = '0;
  logic [15:0] slowPeriod = '0;
  logic [15:0] fastPeriod = '0;
  logic [15:0] blankCycles = '0;
  logic [15:0] maxWidthCycles = '0;
  logic        zeroDetect = 1'b0;
  logic        pulseOut, cycleStart, maxWidthHit;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_term_oneshot i_zero_term_oneshot (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rateCtrl(rateCtrl),
    .slowPeriod(slowPeriod), .fastPeriod(fastPeriod), .blankCycles(blankCycles),
    .maxWidthCycles(maxWidthCycles), .zeroDetect(zeroDetect),
    .pulseOut(pulseOut), .cycleStart(cycleStart), .maxWidthHit(maxWidthHit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPeriod(input int ctrl, input int slow, input int fast);
    int span, p;
    span = (slow > fast) ? slow - fast : 0;
    p = slow - (span * ctrl) / 255;
    return (p < 2) ? 2 : p;
  endfunction

  // zero-limited width before the width cap; d = -3 means held from before
  function automatic int zeroWidth(input int d, input int blank);
    int b;
    b = (blank < 1) ? 1 : blank;
    if (d >= NEVER) return NEVER;
    return (d + 3 > b) ? d + 3 : b;
  endfunction

  function automatic int expWidth(input int d, input int blank, input int maxW);
    int z, m;
    z = zeroWidth(d, blank);
    m = (maxW < 1) ? 1 : maxW;
    return (z <= m) ? z : m;
  endfunction

  function automatic bit expHit(input int d, input int blank, input int maxW);
    int m;
    m = (maxW < 1) ? 1 : maxW;
    return zeroWidth(d, blank) > m;
  endfunction

  task automatic runScenario(input int ctrl, input int slow, input int fast,
                             input int blank, input int maxW, input int d, input int zlen,
                             input int eW, input bit eHit, input string req);
    int eP, width, per;
    @(negedge clk);
    enable = 1'b0;
    rateCtrl = 8'(ctrl);
    slowPeriod = 16'(slow);
    fastPeriod = 16'(fast);
    blankCycles = 16'(blank);
    maxWidthCycles = 16'(maxW);
    zeroDetect = (d < 0);
    repeat (4) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(cycleStart == 1'b1, "R1 first strobe", int'(cycleStart), 1);
    chk(pulseOut == 1'b1, "R3 pulse at strobe", int'(pulseOut), 1);
    eP = expPeriod(ctrl, slow, fast);
    width = -1;
    per = -1;
    for (int j = 0; j < 2000 && per < 0; j++) begin
      if (j == d) zeroDetect = 1'b1;
      if (zlen > 0 && j == d + zlen) zeroDetect = 1'b0;
      if (j > 0 && width < 0 && pulseOut == 1'b0) begin
        width = j;
        chk(maxWidthHit == eHit, {req, " flag"}, int'(maxWidthHit), int'(eHit));
      end
      if (j > 0 && cycleStart) per = j;
      if (per < 0) @(negedge clk);
    end
    chk(width == eW, {req, " width"}, width, eW);
    chk(per == eP, "R2 period", per, eP);
    chk(pulseOut == 1'b1 && maxWidthHit == 1'b0, "R6 flag cleared at next strobe",
        int'({pulseOut, maxWidthHit}), 2);
    zeroDetect = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk({pulseOut, cycleStart, maxWidthHit} == 3'b000, "R9 disable", 
        int'({pulseOut, cycleStart, maxWidthHit}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk({pulseOut, cycleStart, maxWidthHit} == 3'b000, "R10 reset",
        int'({pulseOut, cycleStart, maxWidthHit}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({pulseOut, cycleStart, maxWidthHit} == 3'b000, "R10 idle after reset",
        int'({pulseOut, cycleStart, maxWidthHit}), 0);

    // R2 slowest rate, R6 width limit
    runScenario(0, 100, 20, 8, 30, NEVER, 0, 30, 1'b1, "R6");
    // R2 fastest rate, R5 zero after blanking
    runScenario(255, 100, 20, 4, 12, 2, 0, 5, 1'b0, "R5");
    // R2 inverted limits, R5 zero held from before
    runScenario(128, 30, 80, 3, 10, -3, 0, 3, 1'b0, "R5 held");
    // R2 period floor of 2
    runScenario(0, 1, 0, 1, 1, NEVER, 0, 1, 1'b1, "R6 floor");
    // R4 brief zero inside blanking is ignored
    runScenario(0, 50, 50, 10, 15, 0, 2, 15, 1'b1, "R4");
    // R7 tie between zero end and width limit
    runScenario(7, 60, 60, 4, 9, 6, 0, 9, 1'b0, "R7");
    // R2 mid rate
    runScenario(100, 200, 40, 5, 40, 10, 0, 13, 1'b0, "R5 mid");

    // R8 truncation: period shorter than the width limit
    begin
      bit truncBad;
      int firstBad;
      truncBad = 1'b0;
      firstBad = -1;
      @(negedge clk);
      rateCtrl = 8'd0; slowPeriod = 16'd6; fastPeriod = 16'd6;
      blankCycles = 16'd2; maxWidthCycles = 16'd20; zeroDetect = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      for (int j = 0; j < 18; j++) begin
        if (!pulseOut || maxWidthHit || (cycleStart != (j % 6 == 0))) begin
          truncBad = 1'b1;
          if (firstBad < 0) firstBad = j;
        end
        @(negedge clk);
      end
      chk(!truncBad, "R8 truncation first bad cycle", firstBad, -1);
      enable = 1'b0;
      @(negedge clk);
      chk({pulseOut, cycleStart, maxWidthHit} == 3'b000, "R9 disable mid pulse",
          int'({pulseOut, cycleStart, maxWidthHit}), 0);
    end

    // random scenarios
    for (int n = 0; n < 40; n++) begin
      int slow, fast, ctrl, p, blank, maxW, d, sel;
      slow = 40 + int'($urandom % 160);
      fast = 10 + int'($urandom % (slow - 9));
      ctrl = int'($urandom % 256);
      p = expPeriod(ctrl, slow, fast);
      blank = int'($urandom % 12);
      maxW = 1 + int'($urandom % (p - 4));
      sel = int'($urandom % 4);
      if (sel == 0) d = -3;
      else if (sel == 1) d = NEVER;
      else d = int'($urandom % p);
      runScenario(ctrl, slow, fast, blank, maxW, d, 0,
                  expWidth(d, blank, maxW), expHit(d, blank, maxW),
                  expHit(d, blank, maxW) ? "R6 rand" : "R5 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule